// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial words. Its clock runs at sixteen times the bit rate. The serial line idles high. A falling transition marks the start of a word. The line passes through a synchronizer before any decision is made, so the start edge may arrive at any phase of the clock. The receiver confirms the start bit at its midpoint and then takes every later bit once, near the centre of its bit time. Data arrives least significant bit first.

The word length is selectable from five to eight data bits. After the data bits comes an optional parity bit, with even or odd sense. One stop bit follows. At the stop-bit sample the assembled word moves into a holding register, right-justified. A data-available flag rises at the same time, and the parity-error, framing-error and overrun flags are updated in the same cycle. A single clear input stands for a read of the holding register: it drops data-available and overrun.

Top module: `os_uart_rx`

## Requirements
- R1: While reset is held, and directly after it is released, dataAvail, overrunErr, parityErr, framingErr and rxData are all zero.
- R2: A low level on serialIn that has gone high again by the start-bit midpoint (8 clocks after the low is seen) is treated as noise. It loads no word and leaves every output unchanged.
- R3: Each bit lasts 16 clocks. Data bits are taken least significant bit first, and each is sampled once near the centre of its bit time.
- R4: wordLen selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The received bits sit right-justified in rxData, and every unused upper bit reads zero.
- R5: When parityEn is 1, a parity bit follows the data. parityOdd = 0 selects even parity and parityOdd = 1 selects odd parity, counting the data bits together with the parity bit. parityErr is 1 for a word whose count does not match. When parityEn is 0, parityErr is 0.
- R6: framingErr is 1 for a word whose stop bit is sampled low, and 0 for a word whose stop bit is sampled high.
- R7: At the stop-bit sample the word is loaded into rxData and dataAvail goes to 1. Both are in place before the stop bit ends.
- R8: If dataAvail is still 1 when a new word is loaded, overrunErr goes to 1 with that word. A word loaded while dataAvail is 0 leaves overrunErr at 0.
- R9: A pulse on dataAvailClr, with no load in the same cycle, clears dataAvail and overrunErr on the next clock. rxData is unchanged.
- R10: parityErr and framingErr change only when a word is loaded. They hold their values through idle time and through rejected start pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock at 16 times the bit rate |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| wordLen | input | 2 | Data-bit count minus 5 |
| parityEn | input | 1 | A parity bit follows the data |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| dataAvailClr | input | 1 | Read strobe; clears dataAvail and overrunErr |
| rxData | output | 8 | Holding register, right-justified |
| dataAvail | output | 1 | A word is waiting in the holding register |
| overrunErr | output | 1 | A word was loaded while the previous one was unread |
| parityErr | output | 1 | The parity of the last word did not match |
| framingErr | output | 1 | The stop bit of the last word was low |

## Verification
The assertions check every cycle that a load raises dataAvail and that a clear without a load drops both dataAvail and overrunErr. They also check that a rejected start returns the sequencer to idle, that the bit counter stays inside one bit time, and that the error flags stay stable between loads. Whether the bits land in the right order at the right width, whether parity is judged with the right sense, and whether overrun follows an unread word can only be seen in the bench. The bench shows these by driving whole serial frames and comparing each loaded word with a value computed from the requirements.

// File: rtl/os_uart_rx_pkg.sv
package os_uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic startOk;
    logic shiftBit;
    logic takeParity;
    logic loadHold;
  } rxStrobe_t;

endpackage

// File: rtl/os_uart_rx_ctrl.sv
module os_uart_rx_ctrl
  import os_uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          rxLine,
  input  logic [$clog2(DATA_MAX+1)-1:0] nBits,
  input  logic                          parityEn,
  output rxStrobe_t                     strobe
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_MAX);
  localparam int NB_W  = $clog2(DATA_MAX+1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             atMid;
  logic             atLast;

  assign lastIdx = IDX_W'(nBits - NB_W'(1));
  assign atMid   = (cnt == MID);
  assign atLast  = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt    <= '0;
          bitIdx <= '0;
          if (!rxLine) state <= ST_START;
        end
        ST_START: begin
          if (atMid) begin
            cnt   <= '0;
            state <= rxLine ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (atLast) begin
            cnt <= '0;
            if (bitIdx == lastIdx) begin
              bitIdx <= '0;
              state  <= parityEn ? ST_PARITY : ST_STOP;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PARITY: begin
          if (atLast) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (atLast) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.startOk    = (state == ST_START)  && atMid && !rxLine;
    strobe.shiftBit   = (state == ST_DATA)   && atLast;
    strobe.takeParity = (state == ST_PARITY) && atLast;
    strobe.loadHold   = (state == ST_STOP)   && atLast;
  end

  // R2: a start pulse that is high again at the midpoint is dropped
  a_r2_glitch_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && atMid && rxLine) |=> (state == ST_IDLE));

  // R3: the bit counter never leaves one bit time
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_START) || (cnt <= MID));

  // R3: only one sample strobe fires in any cycle
  a_r3_one_sample: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startOk, strobe.shiftBit, strobe.takeParity, strobe.loadHold}));

  // R7: a load is always followed by a return to idle
  a_r7_load_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHold |=> (state == ST_IDLE));

endmodule

// File: rtl/os_uart_rx_dp.sv
module os_uart_rx_dp
  import os_uart_rx_pkg::*;
#(
  parameter int DATA_MAX    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serialIn,
  input  logic [$clog2(DATA_MAX+1)-1:0] nBits,
  input  logic                          parityEn,
  input  logic                          parityOdd,
  input  logic                          dataAvailClr,
  input  rxStrobe_t                     strobe,
  output logic                          rxLine,
  output logic [DATA_MAX-1:0]           rxData,
  output logic                          dataAvail,
  output logic                          overrunErr,
  output logic                          parityErr,
  output logic                          framingErr
);
  localparam int NB_W = $clog2(DATA_MAX+1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [DATA_MAX-1:0]    shiftReg;
  logic                   parAcc;
  logic                   parBit;
  logic [NB_W-1:0]        shiftAmt;

  assign rxLine   = syncReg[SYNC_STAGES-1];
  assign shiftAmt = NB_W'(DATA_MAX) - nBits;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= serialIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], serialIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.startOk) begin
        parAcc <= 1'b0;
        parBit <= 1'b0;
      end
      if (strobe.shiftBit) begin
        shiftReg <= {rxLine, shiftReg[DATA_MAX-1:1]};
        parAcc   <= parAcc ^ rxLine;
      end
      if (strobe.takeParity) parBit <= rxLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      dataAvail  <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
    end else if (strobe.loadHold) begin
      rxData     <= shiftReg >> shiftAmt;
      dataAvail  <= 1'b1;
      overrunErr <= dataAvail && !dataAvailClr;
      parityErr  <= parityEn && (parAcc ^ parBit ^ parityOdd);
      framingErr <= !rxLine;
    end else if (dataAvailClr) begin
      dataAvail  <= 1'b0;
      overrunErr <= 1'b0;
    end
  end

  // R7: a load leaves a word waiting
  a_r7_load_sets_avail: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHold |=> dataAvail);

  // R9: a clear with no load drops both flags
  a_r9_clear_drops_flags: assert property (@(posedge clk) disable iff (!rstN)
    (dataAvailClr && !strobe.loadHold) |=> (!dataAvail && !overrunErr));

  // R10: error flags hold between loads
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadHold |=> ($stable(parityErr) && $stable(framingErr)));

  // R4: unused upper bits of a fresh word are zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHold |=> ((rxData >> $past(nBits)) == '0));

  // R8: overrun only ever appears with a word waiting
  a_r8_overrun_with_avail: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |-> dataAvail);

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx
  import os_uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_MAX    = 8,
  parameter int MIN_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serialIn,
  input  logic [1:0]          wordLen,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                dataAvailClr,
  output logic [DATA_MAX-1:0] rxData,
  output logic                dataAvail,
  output logic                overrunErr,
  output logic                parityErr,
  output logic                framingErr
);
  localparam int NB_W = $clog2(DATA_MAX+1);

  logic            rxLine;
  logic [NB_W-1:0] nBits;
  rxStrobe_t       strobe;

  assign nBits = NB_W'(MIN_BITS) + NB_W'(wordLen);

  os_uart_rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_MAX  (DATA_MAX)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxLine  (rxLine),
    .nBits   (nBits),
    .parityEn(parityEn),
    .strobe  (strobe)
  );

  os_uart_rx_dp #(
    .DATA_MAX   (DATA_MAX),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .serialIn    (serialIn),
    .nBits       (nBits),
    .parityEn    (parityEn),
    .parityOdd   (parityOdd),
    .dataAvailClr(dataAvailClr),
    .strobe      (strobe),
    .rxLine      (rxLine),
    .rxData      (rxData),
    .dataAvail   (dataAvail),
    .overrunErr  (overrunErr),
    .parityErr   (parityErr),
    .framingErr  (framingErr)
  );

  // R6: a low stop sample leaves a framing error
  a_r6_low_stop_frames: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadHold && !rxLine) |=> framingErr);

endmodule

// File: tb/sim_os_uart_rx.sv
`timescale 1ns/1ps
module sim_os_uart_rx;
  logic       clk = 1'b0;
  logic       rstN;
  logic       serialIn;
  logic [1:0] wordLen;
  logic       parityEn;
  logic       parityOdd;
  logic       dataAvailClr;
  logic [7:0] rxData;
  logic       dataAvail;
  logic       overrunErr;
  logic       parityErr;
  logic       framingErr;

  int checks = 0;
  int fails  = 0;
  bit pending = 0;

  always #2.5 clk = ~clk;

  os_uart_rx u0 (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .wordLen(wordLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .dataAvailClr(dataAvailClr),
    .rxData(rxData), .dataAvail(dataAvail), .overrunErr(overrunErr),
    .parityErr(parityErr), .framingErr(framingErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expWord(input logic [7:0] d, input int n);
    return d & 8'((1 << n) - 1);
  endfunction

  function automatic bit parityBit(input logic [7:0] d, input int n, input bit odd);
    return (^expWord(d, n)) ^ odd;
  endfunction

  task automatic driveBit(input bit b);
    serialIn = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic clearAvail();
    @(negedge clk) dataAvailClr = 1'b1;
    @(negedge clk) dataAvailClr = 1'b0;
    pending = 0;
  endtask

  task automatic sendWord(input logic [7:0] d, input int n, input bit pe,
                          input bit odd, input bit badPar, input bit badStop);
    logic [7:0] want;
    bit         wasPending;
    wordLen   = 2'(n - 5);
    parityEn  = pe;
    parityOdd = odd;
    wasPending = pending;
    driveBit(1'b0);
    for (int i = 0; i < n; i++) driveBit(d[i]);
    if (pe) driveBit(parityBit(d, n, odd) ^ badPar);
    driveBit(!badStop);
    serialIn = 1'b1;
    repeat (24) @(negedge clk);
    want = expWord(d, n);
    chk(dataAvail == 1'b1, "R7 dataAvail after word", dataAvail, 1);
    chk(rxData == want, "R3/R4 rxData", rxData, want);
    chk(parityErr == (pe && badPar), "R5 parityErr", parityErr, pe && badPar);
    chk(framingErr == badStop, "R6 framingErr", framingErr, badStop);
    chk(overrunErr == wasPending, "R8 overrunErr", overrunErr, wasPending);
    pending = 1;
  endtask

  task automatic glitch(input int lowClocks);
    serialIn = 1'b0;
    repeat (lowClocks) @(negedge clk);
    serialIn = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] saved;
    bit         savedPar;
    bit         savedFrm;
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; serialIn = 1'b1; wordLen = 2'd3; parityEn = 1'b0;
    parityOdd = 1'b0; dataAvailClr = 1'b0;
    repeat (5) @(negedge clk);
    chk({dataAvail, overrunErr, parityErr, framingErr} == 4'b0, "R1 flags in reset",
        {dataAvail, overrunErr, parityErr, framingErr}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(rxData == 8'h00, "R1 rxData after reset", rxData, 0);
    chk(dataAvail == 1'b0, "R1 dataAvail after reset", dataAvail, 0);

    // R3 / R4: full width, then five bits with upper bits driven high
    sendWord(8'hA5, 8, 0, 0, 0, 0);
    clearAvail();
    sendWord(8'hFF, 5, 0, 0, 0, 0);
    clearAvail();
    sendWord(8'h96, 6, 0, 0, 0, 0);
    clearAvail();
    // R5: even good, odd bad
    sendWord(8'h5B, 7, 1, 0, 0, 0);
    clearAvail();
    sendWord(8'h3C, 8, 1, 1, 1, 0);
    // R10: flags hold through a rejected start
    clearAvail();
    glitch(4);
    chk(parityErr == 1'b1, "R10 parityErr held", parityErr, 1);
    // R6: low stop bit
    sendWord(8'h81, 8, 0, 0, 0, 1);
    clearAvail();
    chk(dataAvail == 1'b0, "R9 dataAvail cleared", dataAvail, 0);
    // R2: glitch leaves outputs alone
    saved = rxData; savedPar = parityErr; savedFrm = framingErr;
    glitch(5);
    chk(dataAvail == 1'b0, "R2 no word from glitch", dataAvail, 0);
    chk(rxData == saved, "R2 rxData unchanged", rxData, saved);
    chk(framingErr == savedFrm && parityErr == savedPar, "R10 flags unchanged",
        {parityErr, framingErr}, {savedPar, savedFrm});
    // R8 / R9: unread word, then a second word, then clear
    sendWord(8'h11, 8, 0, 0, 0, 0);
    sendWord(8'h22, 8, 0, 0, 0, 0);
    saved = rxData;
    clearAvail();
    chk(overrunErr == 1'b0, "R9 overrun cleared", overrunErr, 0);
    chk(rxData == saved, "R9 rxData kept", rxData, saved);

    for (int k = 0; k < 40; k++) begin
      int n;
      n = 5 + int'($urandom_range(3));
      sendWord(8'($urandom), n, bit'($urandom_range(1)), bit'($urandom_range(1)),
               ($urandom_range(3) == 0), ($urandom_range(5) == 0));
      if ($urandom_range(3) != 0) clearAvail();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule